// File: doc/BRIEF.md
# UART Register Front End with Interrupt Control

This block is the host-visible register window of a simple UART. A host issues single-cycle 32-bit word accesses at byte offsets. The block maps them onto nine byte-wide registers: receive buffer, transmit holding, interrupt enable, interrupt identification, line control, modem control, line status, modem status and divisor. The serial shifter and the baud generator sit outside this block. The divisor value is only stored here.

A write to the transmit holding register hands the character to the transmitter through a valid/ready pair. Before it leaves, the character is cut down to the word length chosen in line control. The transmitter reports that it has finished with a one-cycle done pulse. Bytes from the receiver arrive as one-cycle valid strobes.

Register side effects keep the status and identification bytes up to date. A single level-sensitive interrupt line is raised by transmit completion, by byte arrival, or by enabling the transmit interrupt while the holding register is empty.

Top module: `uart_front`

## Requirements
- R1: After reset, line status reads 0x20 and every other register reads 0x00. At the same time irq, txValid and errFlag are low.
- R2: Offsets follow the register index times four. The index order is 0 data (receive buffer on read, transmit holding on write), 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. A legal write to indices 1 to 7 stores busWData[7:0]. Reads return the stored byte zero-extended to 32 bits.
- R3: A write to index 0 has four effects: it stores the byte, clears line status bit 5 (holding empty), and clears identification bit 1. From the next cycle it also holds txValid high until a cycle in which txReady is high.
- R4: txData is the stored character ANDed with a mask. The mask comes from line control bits [1:0] in effect at the time of the write: 0 gives 0x1F, 1 gives 0x3F, 2 gives 0x7F and 3 gives 0xFF.
- R5: After a txDone pulse, line status bit 5 is set and identification reads 0x02. irq is asserted only if interrupt enable bit 1 (transmit) is set.
- R6: Consider a write to interrupt enable with bit 1 set. If line status bit 5 is set, the write sets identification bit 1 and asserts irq. If bit 5 is clear, irq is unchanged. A write with bit 1 clear deasserts irq. Reads never change irq.
- R7: A rxValid strobe latches rxData into the receive buffer and sets line status bit 0. It also makes identification read 0x04, and asserts irq if interrupt enable bit 0 (receive) is set.
- R8: A read of index 0 returns the received byte and clears line status bit 0.
- R9: A byte that arrives while line status bit 0 is still set replaces the stored byte. It also sets line status bit 1 (overrun), which stays set until line status is written.
- R10: An access is illegal if its offset is past 0x1C, is not word aligned, or has any byte enable low. An illegal access raises busErr in the same cycle and returns read data 0. It changes no register and sets the sticky errFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busByteEn | input | 4 | Byte enables; all four required |
| busWData | input | 32 | Write data; low byte used |
| busRData | output | 32 | Read data, valid in the access cycle |
| busErr | output | 1 | Illegal access response, same cycle |
| errFlag | output | 1 | Sticky illegal-access flag |
| txValid | output | 1 | Character waiting for the transmitter |
| txReady | input | 1 | Transmitter accepts the character |
| txData | output | 8 | Masked character |
| txDone | input | 1 | One-cycle transmission complete pulse |
| rxValid | input | 1 | One-cycle received byte strobe |
| rxData | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions rely on three assumptions about the inputs. txDone arrives only after the character has been accepted. rxValid and txDone never land in the same cycle as a write of the register they also update. A receive buffer read never coincides with a byte arrival. The bench's transmitter model accepts one cycle after txValid rises and pulses done a fixed number of cycles later. Every bus access and receive strobe is issued from a task that runs strictly one cycle at a time, so none of those collisions can occur.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_DATA  = 3'd0,
    IDX_IEN   = 3'd1,
    IDX_IID   = 3'd2,
    IDX_LCTL  = 3'd3,
    IDX_MCTL  = 3'd4,
    IDX_LSTAT = 3'd5,
    IDX_MSTAT = 3'd6,
    IDX_DIV   = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regIdx_e idx;
  } regStrobe_t;

  localparam int STAT_RX_RDY  = 0;
  localparam int STAT_OVERRUN = 1;
  localparam int STAT_TX_EMPT = 5;
  localparam int IEN_RX       = 0;
  localparam int IEN_TX       = 1;
  localparam logic [BYTE_W-1:0] IID_TX = 8'h02;
  localparam logic [BYTE_W-1:0] IID_RX = 8'h04;
  localparam logic [BYTE_W-1:0] STAT_RESET = 8'h20;

  function automatic logic [BYTE_W-1:0] lenMask(input logic [1:0] sel);
    lenMask = BYTE_W'((1 << (5 + int'(sel))) - 1);
  endfunction
endpackage

// File: rtl/uart_front_dpath.sv
module uart_front_dpath
  import uart_front_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [BYTE_W-1:0] wByte,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              txDone,
  output logic [BYTE_W-1:0] rdByte,
  output logic [BYTE_W-1:0] txByte,
  output logic              thrEmpty,
  output logic              ienTx,
  output logic              ienRx
);
  logic [BYTE_W-1:0] rbrQ, txQ, ienQ, iidQ, lctlQ, mctlQ, statQ, mstatQ, divQ;
  logic [BYTE_W-1:0] statD, iidD;
  logic wrData, wrIen, rdData;

  assign wrData = strb.wrEn && (strb.idx == IDX_DATA);
  assign wrIen  = strb.wrEn && (strb.idx == IDX_IEN);
  assign rdData = strb.rdEn && (strb.idx == IDX_DATA);

  always_comb begin
    statD = statQ;
    if (strb.wrEn && strb.idx == IDX_LSTAT) statD = wByte;
    if (wrData) statD[STAT_TX_EMPT] = 1'b0;
    if (rdData) statD[STAT_RX_RDY] = 1'b0;
    if (txDone) statD[STAT_TX_EMPT] = 1'b1;
    if (rxValid) begin
      statD[STAT_RX_RDY] = 1'b1;
      if (statQ[STAT_RX_RDY] && !rdData) statD[STAT_OVERRUN] = 1'b1;
    end
  end

  always_comb begin
    iidD = iidQ;
    if (strb.wrEn && strb.idx == IDX_IID) iidD = wByte;
    if (wrData) iidD[IEN_TX] = 1'b0;
    if (wrIen && wByte[IEN_TX] && statQ[STAT_TX_EMPT]) iidD = iidD | IID_TX;
    if (txDone) iidD = IID_TX;
    if (rxValid) iidD = IID_RX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbrQ <= '0; txQ <= '0; ienQ <= '0; iidQ <= '0; lctlQ <= '0;
      mctlQ <= '0; statQ <= STAT_RESET; mstatQ <= '0; divQ <= '0;
    end else begin
      statQ <= statD;
      iidQ  <= iidD;
      if (rxValid) rbrQ <= rxData;
      if (wrData) txQ <= wByte & lenMask(lctlQ[1:0]);
      if (strb.wrEn) begin
        case (strb.idx)
          IDX_IEN:   ienQ   <= wByte;
          IDX_LCTL:  lctlQ  <= wByte;
          IDX_MCTL:  mctlQ  <= wByte;
          IDX_MSTAT: mstatQ <= wByte;
          IDX_DIV:   divQ   <= wByte;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (strb.idx)
      IDX_DATA:  rdByte = rbrQ;
      IDX_IEN:   rdByte = ienQ;
      IDX_IID:   rdByte = iidQ;
      IDX_LCTL:  rdByte = lctlQ;
      IDX_MCTL:  rdByte = mctlQ;
      IDX_LSTAT: rdByte = statQ;
      IDX_MSTAT: rdByte = mstatQ;
      default:   rdByte = divQ;
    endcase
  end

  assign txByte   = txQ;
  assign thrEmpty = statQ[STAT_TX_EMPT];
  assign ienTx    = ienQ[IEN_TX];
  assign ienRx    = ienQ[IEN_RX];

  AST_THR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wrData && !txDone |=> !statQ[STAT_TX_EMPT]);  // R3
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> statQ[STAT_RX_RDY] && iidQ == IID_RX && rbrQ == $past(rxData));  // R7
  AST_RBR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    rdData && !rxValid |=> !statQ[STAT_RX_RDY]);  // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statQ[STAT_OVERRUN] && !(strb.wrEn && strb.idx == IDX_LSTAT) |=> statQ[STAT_OVERRUN]);  // R9
endmodule

// File: rtl/uart_front_ctrl.sv
module uart_front_ctrl
  import uart_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [BYTE_W-1:0] wByte,
  input  logic [BYTE_W-1:0] rdByte,
  input  logic              thrEmpty,
  input  logic              ienTx,
  input  logic              ienRx,
  input  logic              txReady,
  input  logic              txDone,
  input  logic              rxValid,
  output regStrobe_t        strb,
  output logic [BUS_W-1:0]  busRData,
  output logic              busErr,
  output logic              errFlag,
  output logic              txValid,
  output logic              irq
);
  localparam int LAST_OFF = ((1 << IDX_W) - 1) * 4;

  logic mapped, legal, wrData, wrIen, irqD;

  assign mapped = (busAddr <= ADDR_W'(LAST_OFF)) && (busAddr[1:0] == 2'b00);
  assign legal  = busSel && mapped && (busByteEn == 4'hF);
  assign busErr = busSel && !legal;

  assign strb.wrEn = legal && busWrite;
  assign strb.rdEn = legal && !busWrite;
  assign strb.idx  = regIdx_e'(busAddr[IDX_W+1:2]);

  assign busRData = strb.rdEn ? BUS_W'(rdByte) : '0;

  assign wrData = strb.wrEn && (strb.idx == IDX_DATA);
  assign wrIen  = strb.wrEn && (strb.idx == IDX_IEN);

  always_comb begin
    irqD = irq;
    if (wrIen) begin
      if (!wByte[IEN_TX]) irqD = 1'b0;
      else if (thrEmpty)  irqD = 1'b1;
    end
    if (txDone && ienTx)  irqD = 1'b1;
    if (rxValid && ienRx) irqD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      txValid <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= irqD;
      if (busErr) errFlag <= 1'b1;
      if (wrData) txValid <= 1'b1;
      else if (txReady) txValid <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);  // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);  // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busRData == '0);  // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(txDone || rxValid || wrIen));  // R6
endmodule

// File: rtl/uart_front.sv
module uart_front
  import uart_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  output logic              busErr,
  output logic              errFlag,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  input  logic              txDone,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              irq
);
  regStrobe_t        strb;
  logic [BYTE_W-1:0] rdByte;
  logic              thrEmpty, ienTx, ienRx;
  logic              unusedHighBits;

  assign unusedHighBits = ^busWData[BUS_W-1:BYTE_W];

  uart_front_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .wByte(busWData[BYTE_W-1:0]),
    .rdByte(rdByte), .thrEmpty(thrEmpty), .ienTx(ienTx), .ienRx(ienRx),
    .txReady(txReady), .txDone(txDone), .rxValid(rxValid), .strb(strb),
    .busRData(busRData), .busErr(busErr), .errFlag(errFlag),
    .txValid(txValid), .irq(irq)
  );

  uart_front_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wByte(busWData[BYTE_W-1:0]),
    .rxValid(rxValid), .rxData(rxData), .txDone(txDone), .rdByte(rdByte),
    .txByte(txData), .thrEmpty(thrEmpty), .ienTx(ienTx), .ienRx(ienRx)
  );
endmodule

// File: tb/uart_front_tb_top.sv
module uart_front_tb_top;
  localparam int TX_LAT = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        busErr, errFlag, txValid, irq;
  logic        txReady, txDone;
  logic [7:0]  txData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;

  int nChecks = 0, nFail = 0, txDoneCnt = 0;
  logic [7:0] txSeen;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_front dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWData(busWData),
    .busRData(busRData), .busErr(busErr), .errFlag(errFlag),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txDone(txDone),
    .rxValid(rxValid), .rxData(rxData), .irq(irq)
  );

  // Transmitter model: accept after one cycle, done after a fixed latency
  initial begin
    txReady = 1'b0; txDone = 1'b0; txSeen = '0;
    forever begin
      @(negedge clk);
      if (txValid) begin
        txSeen = txData;
        txReady = 1'b1;
        @(negedge clk);
        txReady = 1'b0;
        repeat (TX_LAT) @(negedge clk);
        txDone = 1'b1;
        @(negedge clk);
        txDone = 1'b0;
        txDoneCnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busAccess(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                           input logic [3:0] be, output logic [31:0] rd, output logic err);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = addr; busWData = wd; busByteEn = be;
    #3;
    rd = busRData; err = busErr;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] rd; logic err;
    busAccess(1'b1, addr, wd, 4'hF, rd, err);
  endtask

  task automatic rdChk(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] rd; logic err;
    busAccess(1'b0, addr, '0, 4'hF, rd, err);
    chk(req, rd, exp);
  endtask

  task automatic rxByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic waitTx(input int target);
    wait (txDoneCnt == target);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    rdChk("R1 status", 8'h14, 32'h20);
    rdChk("R1 ien", 8'h04, 0);
    rdChk("R1 iid", 8'h08, 0);
    rdChk("R1 lctl", 8'h0C, 0);
    rdChk("R1 div", 8'h1C, 0);
  endtask

  task automatic t_regs;
    wr(8'h0C, 32'hFFFF_FF5A);
    wr(8'h10, 32'h0000_0011);
    wr(8'h18, 32'h0000_0033);
    wr(8'h1C, 32'h0000_00A5);
    wr(8'h08, 32'h0000_0040);
    rdChk("R2 lctl", 8'h0C, 32'h5A);
    rdChk("R2 mctl", 8'h10, 32'h11);
    rdChk("R2 mstat", 8'h18, 32'h33);
    rdChk("R2 div", 8'h1C, 32'hA5);
    rdChk("R2 iid", 8'h08, 32'h40);
    wr(8'h08, 0);
  endtask

  task automatic t_tx;
    wr(8'h0C, 32'h3);
    wr(8'h08, 32'h2);
    wr(8'h00, 32'hC3);
    #1 chk("R3 txValid", 32'(txValid), 1);
    rdChk("R3 status empty clear", 8'h14, 32'h00);
    rdChk("R3 iid bit1 clear", 8'h08, 32'h00);
    waitTx(1);
    chk("R3 char", 32'(txSeen), 32'hC3);
    chk("R3 txValid dropped", 32'(txValid), 0);
    rdChk("R5 status", 8'h14, 32'h20);
    rdChk("R5 iid", 8'h08, 32'h02);
    chk("R5 irq off", 32'(irq), 0);
  endtask

  task automatic t_mask;
    for (int wl = 0; wl < 4; wl++) begin
      wr(8'h0C, 32'(wl));
      wr(8'h00, 32'hFF);
      waitTx(2 + wl);
      chk("R4 mask", 32'(txSeen), 32'((1 << (5 + wl)) - 1));
    end
    wr(8'h0C, 32'h3);
  endtask

  task automatic t_txirq;
    wr(8'h04, 32'h2);
    #1 chk("R6 irq raise", 32'(irq), 1);
    rdChk("R6 iid", 8'h08, 32'h02);
    rdChk("R6 read keeps irq", 8'h04, 32'h02);
    chk("R6 irq after read", 32'(irq), 1);
    wr(8'h04, 32'h0);
    #1 chk("R6 irq drop", 32'(irq), 0);
    wr(8'h00, 32'h5A);
    wr(8'h04, 32'h2);
    #1 chk("R6 busy no irq", 32'(irq), 0);
    rdChk("R6 busy iid", 8'h08, 32'h00);
    waitTx(6);
    chk("R5 irq on", 32'(irq), 1);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_rx;
    wr(8'h04, 32'h1);
    rxByte(8'h5C);
    chk("R7 irq", 32'(irq), 1);
    rdChk("R7 status", 8'h14, 32'h21);
    rdChk("R7 iid", 8'h08, 32'h04);
    rdChk("R8 data", 8'h00, 32'h5C);
    rdChk("R8 status cleared", 8'h14, 32'h20);
    wr(8'h04, 32'h0);
    #1 chk("R6 irq drop rx", 32'(irq), 0);
  endtask

  task automatic t_overrun;
    rxByte(8'h11);
    rxByte(8'h22);
    chk("R7 irq masked", 32'(irq), 0);
    rdChk("R9 status", 8'h14, 32'h23);
    rdChk("R9 data", 8'h00, 32'h22);
    rdChk("R9 sticky", 8'h14, 32'h22);
    wr(8'h14, 32'h20);
    rdChk("R9 cleared by write", 8'h14, 32'h20);
  endtask

  task automatic t_err;
    logic [31:0] rd; logic err;
    chk("R10 flag before", 32'(errFlag), 0);
    busAccess(1'b0, 8'h20, '0, 4'hF, rd, err);
    chk("R10 unmapped err", 32'(err), 1);
    chk("R10 unmapped data", rd, 0);
    busAccess(1'b0, 8'h0C, '0, 4'h3, rd, err);
    chk("R10 partial err", 32'(err), 1);
    chk("R10 partial data", rd, 0);
    busAccess(1'b1, 8'h0C, 32'h77, 4'h7, rd, err);
    chk("R10 partial write err", 32'(err), 1);
    busAccess(1'b1, 8'h0E, 32'h77, 4'hF, rd, err);
    chk("R10 misaligned err", 32'(err), 1);
    rdChk("R10 lctl untouched", 8'h0C, 32'h03);
    chk("R10 sticky", 32'(errFlag), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_regs();
    t_tx();
    t_mask();
    t_txirq();
    t_rx();
    t_overrun();
    t_err();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule